// File: doc/BRIEF.md
# Self-Selecting Multi-Style Host Bus Front End

This block connects an 8-bit host processor to two internal register spaces. It accepts three bus styles and chooses one by watching the address-latch-enable input. If that input is held high, the block uses a strobe-and-direction style: one data strobe, one read/write line and a chip select. If it is held low, the block uses separate active-low read and write strobes with a dedicated address bus. The first transition of the latch-enable input in either direction switches the block to a multiplexed style. In that style the address travels on the shared data lines while latch-enable is high. The multiplexed style stays selected until a hardware reset.

Every host access becomes one access on a single internal port. That port carries the address, the write data, a space select, and single-cycle write and read pulses. Two active-low chip selects choose the target space. Space A holds the serial-controller registers and FIFOs. Space B holds the switching, arbiter, port and watchdog registers. All host inputs pass through a two-flop synchroniser before any decision is made.

The access sequencer is a state machine with four states:
- IDLE waits for a strobe.
- READ_ACT covers a read that is in progress.
- WRITE_ACT covers a write that is in progress.
- SKIP absorbs an illegal access until its strobe is released.

The transitions are:
- IDLE→READ_ACT when a read strobe arrives with exactly one chip select.
- IDLE→WRITE_ACT when a write strobe arrives with exactly one chip select.
- IDLE→SKIP when a strobe arrives with both chip selects.
- READ_ACT→IDLE, WRITE_ACT→IDLE and SKIP→IDLE when the strobe is released.

Top module: `hostbus_autodetect`

## Requirements
- R1: With latch-enable held high from reset and never toggled, `bus_mode` reads 1 (strobe-and-direction style). In this style `rd_n` is the active-low data strobe and `wr_n` is the direction line, where 1 means read and 0 means write.
- R2: With latch-enable held low from reset and never toggled, `bus_mode` reads 0 (separate strobes). In this style `rd_n` and `wr_n` are the active-low read and write strobes, and the address is taken from `addr_in`.
- R3: A rising or falling edge on `ale` after reset sets `bus_mode` to 2 (multiplexed) within 4 clock cycles.
- R4: Once `bus_mode` is 2 it stays 2 until reset. After reset the mode follows the `ale` level again, as in R1 and R2.
- R5: In multiplexed mode the access address is the value on `ad_in` while `ale` was high, and `addr_in` is ignored. The data phase then uses `rd_n` and `wr_n` as separate strobes.
- R6: Each host write produces exactly one `reg_wr` pulse of one cycle. The pulse is issued after the strobe is released, and it carries the host address and the data held on `ad_in` during the strobe.
- R7: Each host read produces exactly one `reg_rd` pulse of one cycle when the strobe is recognised. While the read is active, `ad_oe` is 1 and `ad_out` carries the read data of the selected space. At all other times `ad_oe` is 0.
- R8: `cs_a_n`=0 sets `reg_sel`=0 and routes read data from `reg_rdata_a`. `cs_b_n`=0 sets `reg_sel`=1 and routes read data from `reg_rdata_b`.
- R9: A strobe with both chip selects low produces no `reg_wr` or `reg_rd` pulse and leaves `ad_oe` at 0.
- R10: A strobe with neither chip select low produces no internal pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low hardware reset |
| ale | input | 1 | Address-latch-enable; its level or activity selects the bus style |
| cs_a_n | input | 1 | Active-low select for space A |
| cs_b_n | input | 1 | Active-low select for space B |
| rd_n | input | 1 | Read strobe, or data strobe in strobe-and-direction style |
| wr_n | input | 1 | Write strobe, or read/write direction line (1 = read) |
| addr_in | input | 8 | Address bus for the non-multiplexed styles |
| ad_in | input | 8 | Data bus in; also carries the address in multiplexed style |
| ad_out | output | 8 | Read data toward the host |
| ad_oe | output | 1 | Enable for driving the host data bus |
| bus_mode | output | 2 | Selected style: 0 separate strobes, 1 strobe-and-direction, 2 multiplexed |
| reg_addr | output | 8 | Internal access address |
| reg_wdata | output | 8 | Internal write data |
| reg_sel | output | 1 | Internal space select (0 = A, 1 = B) |
| reg_wr | output | 1 | Internal write pulse |
| reg_rd | output | 1 | Internal read pulse |
| reg_rdata_a | input | 8 | Read data from space A |
| reg_rdata_b | input | 8 | Read data from space B |

## Verification
The assertions check properties that must hold on every cycle:
- the multiplexed mode never reverts before a reset;
- write and read pulses last one cycle and never coincide;
- the bus drive starts together with a read pulse and never overlaps a write;
- the mode code is always legal.

Other behaviour can only be shown by the bench scenarios. These cover:
- the mode chosen from the latch-enable level after each reset;
- the switch caused by an edge in the middle of operation;
- the address taken from the shared bus in multiplexed mode;
- the data and space routing of each access;
- the absence of any internal pulse when both or neither chip selects are active.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;

    localparam logic [1:0] MODE_SEP  = 2'd0;
    localparam logic [1:0] MODE_DIR  = 2'd1;
    localparam logic [1:0] MODE_MUX  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ_ACT,
        ST_WRITE_ACT,
        ST_SKIP
    } acc_state_e;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/hbi_mode_detect.sv
module hbi_mode_detect #(
    parameter int FILL_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ale_s,
    output logic [1:0] mode
);
    import hbi_pkg::*;

    localparam int FILL_W = $clog2(FILL_CYCLES + 1);

    logic [FILL_W-1:0] fill_q;
    logic              ale_prev_q;
    logic              mux_q;
    logic              armed;

    assign armed = (fill_q == FILL_W'(FILL_CYCLES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q     <= '0;
            ale_prev_q <= 1'b0;
            mux_q      <= 1'b0;
        end else begin
            ale_prev_q <= ale_s;
            if (!armed) begin
                fill_q <= fill_q + 1'b1;
            end
            if (armed && (ale_s != ale_prev_q)) begin
                mux_q <= 1'b1;
            end
        end
    end

    always_comb begin
        if (mux_q) begin
            mode = MODE_MUX;
        end else if (ale_s) begin
            mode = MODE_DIR;
        end else begin
            mode = MODE_SEP;
        end
    end
endmodule

// File: rtl/hbi_access_fsm.sv
module hbi_access_fsm #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir_style,
    input  logic          rd_pin_n,
    input  logic          wr_pin_n,
    input  logic          sel_a,
    input  logic          sel_b,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] wdata_in,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_sel,
    output logic          reg_wr,
    output logic          reg_rd,
    output logic          drive_en
);
    import hbi_pkg::*;

    acc_state_e state_q, state_d;
    logic rd_req, wr_req, one_cs, both_cs, start_rd, start_wr;

    always_comb begin
        if (dir_style) begin
            rd_req = !rd_pin_n && wr_pin_n;
            wr_req = !rd_pin_n && !wr_pin_n;
        end else begin
            rd_req = !rd_pin_n;
            wr_req = !wr_pin_n;
        end
    end

    assign one_cs   = sel_a ^ sel_b;
    assign both_cs  = sel_a & sel_b;
    assign start_rd = rd_req && one_cs;
    assign start_wr = wr_req && one_cs && !rd_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if ((rd_req || wr_req) && both_cs) begin
                    state_d = ST_SKIP;
                end else if (start_rd) begin
                    state_d = ST_READ_ACT;
                end else if (start_wr) begin
                    state_d = ST_WRITE_ACT;
                end
            end
            ST_READ_ACT:  if (!rd_req) state_d = ST_IDLE;
            ST_WRITE_ACT: if (!wr_req) state_d = ST_IDLE;
            ST_SKIP:      if (!rd_req && !wr_req) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_sel   <= 1'b0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
        end else begin
            reg_rd <= (state_q == ST_IDLE) && (state_d == ST_READ_ACT);
            reg_wr <= (state_q == ST_WRITE_ACT) && (state_d == ST_IDLE);
            if ((state_q == ST_IDLE) && (state_d == ST_READ_ACT || state_d == ST_WRITE_ACT)) begin
                reg_addr <= acc_addr;
                reg_sel  <= sel_b;
            end
            if ((state_q == ST_IDLE && state_d == ST_WRITE_ACT) ||
                (state_q == ST_WRITE_ACT && wr_req)) begin
                reg_wdata <= wdata_in;
            end
        end
    end

    assign drive_en = (state_q == ST_READ_ACT);
endmodule

// File: rtl/hostbus_autodetect.sv
module hostbus_autodetect #(
    parameter int AW = hbi_pkg::ADDR_W,
    parameter int DW = hbi_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ale,
    input  logic          cs_a_n,
    input  logic          cs_b_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic [1:0]    bus_mode,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_sel,
    output logic          reg_wr,
    output logic          reg_rd,
    input  logic [DW-1:0] reg_rdata_a,
    input  logic [DW-1:0] reg_rdata_b
);
    import hbi_pkg::*;

    localparam int CTRL_W = 5;
    localparam int SYNC_W = CTRL_W + AW + DW;
    localparam logic [SYNC_W-1:0] SYNC_RST = {5'b01111, {(AW + DW){1'b0}}};

    logic [SYNC_W-1:0] sync_out;
    logic              ale_s, rd_s, wr_s, csa_s, csb_s;
    logic [AW-1:0]     addr_s;
    logic [DW-1:0]     ad_s;
    logic [AW-1:0]     addr_latch_q;
    logic [AW-1:0]     acc_addr;

    hbi_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ale, rd_n, wr_n, cs_a_n, cs_b_n, addr_in, ad_in}),
        .q     (sync_out)
    );

    assign {ale_s, rd_s, wr_s, csa_s, csb_s, addr_s, ad_s} = sync_out;

    hbi_mode_detect #(.FILL_CYCLES(3)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .ale_s (ale_s),
        .mode  (bus_mode)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_latch_q <= '0;
        end else if (ale_s) begin
            addr_latch_q <= AW'(ad_s);
        end
    end

    assign acc_addr = (bus_mode == MODE_MUX) ? addr_latch_q : addr_s;

    hbi_access_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_style (bus_mode == MODE_DIR),
        .rd_pin_n  (rd_s),
        .wr_pin_n  (wr_s),
        .sel_a     (!csa_s),
        .sel_b     (!csb_s),
        .acc_addr  (acc_addr),
        .wdata_in  (ad_s),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .drive_en  (ad_oe)
    );

    assign ad_out = ad_oe ? (reg_sel ? reg_rdata_b : reg_rdata_a) : '0;
endmodule

// File: rtl/hbi_checker.sv
module hbi_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_mode,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic       ad_oe
);
    a_r4_mux_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mode == 2'd2) |=> (bus_mode == 2'd2));

    a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mode != 2'd3);

    a_r6_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    a_r7_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    a_r6_wr_rd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    a_r7_oe_with_rd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ad_oe) |-> reg_rd);

    a_r7_no_oe_on_wr: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !ad_oe);
endmodule

bind hostbus_autodetect hbi_checker u_hbi_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_mode (bus_mode),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .ad_oe    (ad_oe)
);

// File: tb/hostbus_autodetect_tb_top.sv
module hostbus_autodetect_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ale = 1'b0;
    logic       cs_a_n = 1'b1;
    logic       cs_b_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] addr_in = '0;
    logic [7:0] ad_in = '0;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic [1:0] bus_mode;
    logic [7:0] reg_addr, reg_wdata;
    logic       reg_sel, reg_wr, reg_rd;
    logic [7:0] reg_rdata_a, reg_rdata_b;

    int checks = 0;
    int failures = 0;

    typedef struct {
        bit       is_wr;
        bit       sel;
        bit [7:0] addr;
        bit [7:0] data;
    } exp_item_t;

    exp_item_t exp_q[$];
    logic [7:0] mem_a [0:255];
    logic [7:0] mem_b [0:255];
    logic [7:0] mdl_a [0:255];
    logic [7:0] mdl_b [0:255];

    always #5 clk = ~clk;

    hostbus_autodetect dut_i (
        .clk(clk), .rst_n(rst_n), .ale(ale), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
        .rd_n(rd_n), .wr_n(wr_n), .addr_in(addr_in), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .bus_mode(bus_mode),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata_a(reg_rdata_a), .reg_rdata_b(reg_rdata_b)
    );

    // register-space stubs
    assign reg_rdata_a = mem_a[reg_addr];
    assign reg_rdata_b = mem_b[reg_addr];
    always @(posedge clk) begin
        if (reg_wr) begin
            if (reg_sel) mem_b[reg_addr] <= reg_wdata;
            else         mem_a[reg_addr] <= reg_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: every internal pulse must match the next expected item
    always @(negedge clk) begin
        if (rst_n && (reg_wr || reg_rd)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9/R10 unexpected internal pulse", {reg_wr, reg_rd, reg_addr}, 0);
            end else begin
                exp_item_t e;
                e = exp_q.pop_front();
                check(reg_wr == e.is_wr && reg_rd == !e.is_wr, "R6/R7 pulse kind",
                      {reg_wr, reg_rd}, {e.is_wr, !e.is_wr});
                check(reg_sel == e.sel, "R8 space select", reg_sel, e.sel);
                check(reg_addr == e.addr, "R5/R6 access address", reg_addr, e.addr);
                if (e.is_wr) check(reg_wdata == e.data, "R6 write data", reg_wdata, e.data);
            end
        end
    end

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cs(input int csel);
        cs_a_n = !(csel == 0 || csel == 2);
        cs_b_n = !(csel == 1 || csel == 2);
    endtask

    // style: 0 separate strobes, 1 strobe+direction, 2 multiplexed; csel: 0 A,1 B,2 both,3 none
    task automatic host_write(input int style, input int csel, input bit [7:0] a, input bit [7:0] d);
        exp_item_t e;
        if (csel < 2) begin
            e.is_wr = 1'b1; e.sel = (csel == 1); e.addr = a; e.data = d;
            exp_q.push_back(e);
            if (csel == 1) mdl_b[a] = d; else mdl_a[a] = d;
        end
        @(negedge clk);
        if (style == 2) begin
            ad_in = a; addr_in = ~a; ale = 1'b1; clks(4);
            ale = 1'b0; clks(4);
        end else begin
            addr_in = a;
        end
        ad_in = d;
        set_cs(csel);
        if (style == 1) begin
            wr_n = 1'b0; clks(2); rd_n = 1'b0; clks(6); rd_n = 1'b1; clks(4); wr_n = 1'b1;
        end else begin
            clks(2); wr_n = 1'b0; clks(6); wr_n = 1'b1; clks(4);
        end
        ad_in = 8'hEE;
        set_cs(3);
        clks(4);
        check(ad_oe == 1'b0, "R7 no drive after write", ad_oe, 0);
    endtask

    task automatic host_read(input int style, input int csel, input bit [7:0] a);
        exp_item_t e;
        bit [7:0] expd;
        if (csel < 2) begin
            e.is_wr = 1'b0; e.sel = (csel == 1); e.addr = a; e.data = 8'h00;
            exp_q.push_back(e);
        end
        expd = (csel == 1) ? mdl_b[a] : mdl_a[a];
        @(negedge clk);
        if (style == 2) begin
            ad_in = a; addr_in = ~a; ale = 1'b1; clks(4);
            ale = 1'b0; clks(4);
        end else begin
            addr_in = a;
        end
        set_cs(csel);
        clks(2);
        if (style == 1) wr_n = 1'b1;
        rd_n = 1'b0;
        clks(6);
        if (csel < 2) begin
            check(ad_oe == 1'b1, "R7 drive during read", ad_oe, 1);
            check(ad_out == expd, "R7/R8 read data", ad_out, expd);
        end else begin
            check(ad_oe == 1'b0, "R9/R10 no drive on illegal select", ad_oe, 0);
        end
        rd_n = 1'b1;
        clks(4);
        set_cs(3);
        clks(4);
        check(ad_oe == 1'b0, "R7 drive released", ad_oe, 0);
    endtask

    task automatic do_reset(input bit ale_lvl);
        @(negedge clk);
        rst_n = 1'b0; ale = ale_lvl; rd_n = 1'b1; wr_n = 1'b1; set_cs(3);
        clks(3);
        rst_n = 1'b1;
        clks(8);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_a[i] = '0; mem_b[i] = '0; mdl_a[i] = '0; mdl_b[i] = '0;
        end
        rst_n = 1'b0;
        clks(3);
        check(reg_wr == 0 && reg_rd == 0 && ad_oe == 0, "R7 reset outputs quiet",
              {reg_wr, reg_rd, ad_oe}, 0);
        rst_n = 1'b1;
        clks(8);
        check(bus_mode == 2'd0, "R2 separate-strobe mode with ale low", bus_mode, 0);

        // R2/R6/R7/R8 separate strobes
        host_write(0, 0, 8'h12, 8'hA5);
        host_write(0, 1, 8'h12, 8'h3C);
        host_read (0, 0, 8'h12);
        host_read (0, 1, 8'h12);
        // R9 both selects, R10 no select: no pulse, content unchanged
        host_write(0, 2, 8'h12, 8'hFF);
        host_write(0, 3, 8'h12, 8'h77);
        host_read (0, 2, 8'h12);
        host_read (0, 0, 8'h12);
        host_read (0, 1, 8'h12);
        check(bus_mode == 2'd0, "R2 mode unchanged", bus_mode, 0);

        // R1 strobe-and-direction style
        do_reset(1'b1);
        check(bus_mode == 2'd1, "R1 direction mode with ale high", bus_mode, 1);
        host_write(1, 0, 8'h40, 8'h81);
        host_write(1, 1, 8'h41, 8'h92);
        host_read (1, 0, 8'h40);
        host_read (1, 1, 8'h41);
        check(bus_mode == 2'd1, "R1 mode held without edge", bus_mode, 1);

        // R3 edge in mid-operation
        @(negedge clk); ale = 1'b0;
        clks(4);
        check(bus_mode == 2'd2, "R3 falling edge selects multiplexed", bus_mode, 2);

        // R5 multiplexed accesses, R4 stickiness across further ale activity
        host_write(2, 0, 8'h5A, 8'h66);
        host_write(2, 1, 8'hC3, 8'h19);
        host_read (2, 0, 8'h5A);
        host_read (2, 1, 8'hC3);
        host_read (2, 0, 8'h40);
        check(bus_mode == 2'd2, "R4 multiplexed mode sticky", bus_mode, 2);

        // R4 reset returns to level-selected mode
        do_reset(1'b0);
        check(bus_mode == 2'd0, "R4 reset restores separate-strobe mode", bus_mode, 0);
        host_read (0, 0, 8'h5A);
        host_write(0, 1, 8'h07, 8'hD1);
        host_read (0, 1, 8'h07);

        // R3 rising edge from separate-strobe mode
        @(negedge clk); ale = 1'b1;
        clks(4);
        check(bus_mode == 2'd2, "R3 rising edge selects multiplexed", bus_mode, 2);

        clks(4);
        check(exp_q.size() == 0, "R6/R7 every expected pulse seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule